// File: doc/BRIEF.md
# Event Status Register with Level Interrupt

This block collects single-cycle event pulses from a cell segmentation and reassembly engine. Each pulse sets its own bit in an 11-bit status vector. The events cover:

- a descriptor handed to a completion ring;
- a free-buffer ring whose first entry is still owned by the host;
- a completion ring entry that has not been released;
- the two freeze conditions;
- the host bus error flags;
- a loopback event.

The host sees the vector through a 32-bit read port, and the bits above the event field read as zero.

A read strobe returns the current vector in the same cycle. At the clock edge that ends the read, it clears every bit except three: transmit freeze and the two bus error flags. Those three stay set until the host writes ones to them through a write-one-to-clear strobe, or until reset. A separate enable mask, which can only be written, decides which bits drive the interrupt output. The interrupt is a level: it stays asserted for as long as a set bit remains enabled.

Top module: `sar_evt_status`

## Requirements
- R1: After reset every status bit and every mask bit is zero, `irq_o` is low and a read returns zero.
- R2: A pulse on `evt_set_i[i]` sets status bit i at the next rising edge. The bit assignments are:
  - 0: rx completion update
  - 1: tx completion update
  - 2: rx small-free not available
  - 3: rx big-free not available
  - 4: rx completion not available
  - 5: tx completion not available
  - 6: tx freeze
  - 7: rx freeze
  - 8: bus error ack
  - 9: bus late error
  - 10: loopback
- R3: When a set pulse and a clearing action (a read or a write-one-to-clear) land on the same bit in the same cycle, the bit ends up set.
- R4: While `rd_en_i` is high, `rd_data_o` shows the current status in bits 10:0 and zeros in bits 31:11. At the edge that ends that cycle, every status bit except 6, 8 and 9 is cleared.
- R5: Bits 6, 8 and 9 keep their value across any number of reads.
- R6: While `w1c_en_i` is high, each bit (any position) with a one in `w1c_data_i` is cleared at the next edge. Bits with a zero in `w1c_data_i` keep their value.
- R7: `mask_we_i` loads `mask_wdata_i` into the mask at the next edge. `irq_o` is high exactly when some status bit and its mask bit are both set, so a zero mask keeps `irq_o` low.
- R8: Once high, `irq_o` stays high until every causing bit is cleared or masked off. It does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 11 | Single-cycle event pulses, one per status bit |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 32 | Read data: status in 10:0, zeros above |
| w1c_en_i | input | 1 | Write-one-to-clear strobe |
| w1c_data_i | input | 11 | Bits to clear on a write-one-to-clear |
| mask_we_i | input | 1 | Interrupt-enable mask write strobe |
| mask_wdata_i | input | 11 | New interrupt-enable mask |
| irq_o | output | 1 | Level interrupt request |

## Verification
An event pulse can arrive in the same cycle as a host read or a write-one-to-clear that targets the same bit. The bench provokes this for every bit position: it drives the set pulse together with the clearing strobe, whether the bit is idle or already set. It then judges the result with a following read and with the interrupt level under a full mask. The expected value of each bit comes from a bench-side model in which set dominates clear and only bits 6, 8 and 9 survive a read.

// File: rtl/sar_evt_pkg.sv
package sar_evt_pkg;

    localparam int EVT_W    = 11;
    localparam int HOST_W   = 32;

    // Bit positions in the status vector (host software decodes these).
    localparam int B_RX_CMPL_UPD   = 0;
    localparam int B_TX_CMPL_UPD   = 1;
    localparam int B_RX_SFREE_NA   = 2;
    localparam int B_RX_BFREE_NA   = 3;
    localparam int B_RX_CMPL_NA    = 4;
    localparam int B_TX_CMPL_NA    = 5;
    localparam int B_TX_FREEZE     = 6;
    localparam int B_RX_FREEZE     = 7;
    localparam int B_BUS_ERR_ACK   = 8;
    localparam int B_BUS_LATE_ERR  = 9;
    localparam int B_LOOPBACK      = 10;

    // Bits that survive a host read.
    localparam logic [EVT_W-1:0] KEEP_ON_READ =
        (EVT_W'(1) << B_TX_FREEZE) |
        (EVT_W'(1) << B_BUS_ERR_ACK) |
        (EVT_W'(1) << B_BUS_LATE_ERR);

    typedef struct packed {
        logic q;
    } bit_state_t;

endpackage

// File: rtl/evt_status_bit.sv
module evt_status_bit #(
    parameter bit KEEP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic w1c_i,
    output logic q_o
);
    import sar_evt_pkg::*;

    bit_state_t st_d, st_q;
    logic       rd_clr;

    // Reads only clear bits that are not marked to keep.
    assign rd_clr = rd_i & ~KEEP;

    always_comb begin
        st_d = st_q;
        if (rd_clr || w1c_i) begin
            st_d.q = 1'b0;
        end
        if (set_i) begin
            st_d.q = 1'b1;   // set dominates any clear
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;

    // R2 / R3: a set pulse always leaves the bit set.
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    generate
        if (KEEP) begin : g_keep
            // R5: reads alone never drop a kept bit.
            a_r5_keep_on_read: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o && !w1c_i) |=> q_o);
        end else begin : g_clr
            // R4: read without a set clears the bit.
            a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_i && !set_i) |=> !q_o);
        end
    endgenerate

    // R6: write-one-to-clear without a set clears the bit.
    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_i && !set_i) |=> !q_o);

endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    // R7: without a write the mask is unchanged.
    a_r7_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_o));

endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen #(
    parameter int W = 11
) (
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);
    always_comb begin
        irq_o = |(status_i & mask_i);
    end
endmodule

// File: rtl/sar_evt_status.sv
module sar_evt_status #(
    parameter int                                EVT_W  = sar_evt_pkg::EVT_W,
    parameter int                                HOST_W = sar_evt_pkg::HOST_W,
    parameter logic [sar_evt_pkg::EVT_W-1:0]     KEEP_M = sar_evt_pkg::KEEP_ON_READ
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_set_i,
    input  logic              rd_en_i,
    output logic [HOST_W-1:0] rd_data_o,
    input  logic              w1c_en_i,
    input  logic [EVT_W-1:0]  w1c_data_i,
    input  logic              mask_we_i,
    input  logic [EVT_W-1:0]  mask_wdata_i,
    output logic              irq_o
);
    localparam int PAD_W = HOST_W - EVT_W;

    logic [EVT_W-1:0] status;
    logic [EVT_W-1:0] mask;
    logic [EVT_W-1:0] w1c_vec;

    assign w1c_vec = w1c_data_i & {EVT_W{w1c_en_i}};

    genvar gi;
    generate
        for (gi = 0; gi < EVT_W; gi++) begin : g_bit
            evt_status_bit #(.KEEP(KEEP_M[gi])) u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (evt_set_i[gi]),
                .rd_i  (rd_en_i),
                .w1c_i (w1c_vec[gi]),
                .q_o   (status[gi])
            );
        end
    endgenerate

    evt_mask_reg #(.W(EVT_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask)
    );

    evt_irq_gen #(.W(EVT_W)) u_irq (
        .status_i (status),
        .mask_i   (mask),
        .irq_o    (irq_o)
    );

    assign rd_data_o = {{PAD_W{1'b0}}, status};

    // R8: the level holds while nothing can clear a cause or drop a mask bit.
    a_r8_irq_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_en_i && !w1c_en_i && !mask_we_i) |=> irq_o);

    // R7: an all-zero mask keeps the interrupt quiet.
    a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

    // R2: a fresh event with its enable set raises the interrupt next cycle.
    a_r2_event_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_set_i & mask) && !mask_we_i) |=> irq_o);

endmodule

// File: tb/sar_evt_status_tb.sv
`timescale 1ns/1ps
module sar_evt_status_tb;
    localparam int N = 11;
    localparam logic [N-1:0] KEEP = 11'h340;   // bits 6, 8, 9
    localparam logic [N-1:0] ALL  = 11'h7FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_set_i = '0;
    logic          rd_en_i = 1'b0;
    logic [31:0]   rd_data_o;
    logic          w1c_en_i = 1'b0;
    logic [N-1:0]  w1c_data_i = '0;
    logic          mask_we_i = 1'b0;
    logic [N-1:0]  mask_wdata_i = '0;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0] m_stat = '0;
    logic [N-1:0] m_mask = '0;

    always #2.5 clk = ~clk;

    sar_evt_status u_dut (
        .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .w1c_en_i(w1c_en_i), .w1c_data_i(w1c_data_i),
        .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // One cycle of stimulus, driven at a falling edge; model updated afterwards.
    task automatic cyc(input string req, input logic [N-1:0] set, input logic rd,
                       input logic w1c, input logic [N-1:0] w1d,
                       input logic mwe, input logic [N-1:0] md);
        evt_set_i = set; rd_en_i = rd; w1c_en_i = w1c; w1c_data_i = w1d;
        mask_we_i = mwe; mask_wdata_i = md;
        #1;
        if (rd) chk({req, " read data"}, rd_data_o, {21'b0, m_stat});
        @(negedge clk);
        if (rd)  m_stat = m_stat & KEEP;
        if (w1c) m_stat = m_stat & ~w1d;
        m_stat = m_stat | set;
        if (mwe) m_mask = md;
        evt_set_i = '0; rd_en_i = 1'b0; w1c_en_i = 1'b0; w1c_data_i = '0;
        mask_we_i = 1'b0; mask_wdata_i = '0;
        chk({req, " irq"}, {31'b0, irq_o}, {31'b0, |(m_stat & m_mask)});
    endtask

    initial begin
        #(5.0 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq after reset", {31'b0, irq_o}, 32'd0);
        cyc("R1", '0, 1'b1, 1'b0, '0, 1'b0, '0);
        // R7: events with zero mask leave irq low
        cyc("R7 zero mask", ALL, 1'b0, 1'b0, '0, 1'b0, '0);
        cyc("R6 clear all", '0, 1'b0, 1'b1, ALL, 1'b1, ALL);

        // R2/R4/R5/R6 sweep over every bit position
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            cyc("R2 set", b, 1'b0, 1'b0, '0, 1'b0, '0);
            cyc("R4 first read", '0, 1'b1, 1'b0, '0, 1'b0, '0);
            cyc("R5 second read", '0, 1'b1, 1'b0, '0, 1'b0, '0);
            cyc("R6 w1c", '0, 1'b0, 1'b1, b, 1'b0, '0);
            cyc("R6 check clear", '0, 1'b1, 1'b0, '0, 1'b0, '0);
        end

        // R3: set and read in the same cycle, idle and already-set bit
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            cyc("R3 set+read idle", b, 1'b1, 1'b0, '0, 1'b0, '0);
            cyc("R3 set+read again", b, 1'b1, 1'b0, '0, 1'b0, '0);
            cyc("R3 set+w1c", b, 1'b0, 1'b1, b, 1'b0, '0);
            cyc("R3 verify", '0, 1'b1, 1'b0, '0, 1'b0, '0);
            cyc("R6 tidy", '0, 1'b0, 1'b1, ALL, 1'b0, '0);
        end

        // R6: zero write-one-to-clear data changes nothing
        cyc("R6 set all", ALL, 1'b0, 1'b0, '0, 1'b0, '0);
        cyc("R6 w1c zero", '0, 1'b0, 1'b1, '0, 1'b0, '0);
        cyc("R6 verify", '0, 1'b1, 1'b0, '0, 1'b0, '0);
        cyc("R6 tidy", '0, 1'b0, 1'b1, ALL, 1'b0, '0);

        // R7/R8: mask sweep, level hold, unmask drop
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            cyc("R7 single mask", '0, 1'b0, 1'b0, '0, 1'b1, b);
            cyc("R7 others only", ALL & ~b, 1'b0, 1'b0, '0, 1'b0, '0);
            cyc("R7 own bit", b, 1'b0, 1'b0, '0, 1'b0, '0);
            for (int k = 0; k < 3; k++)
                cyc("R8 hold", '0, 1'b0, 1'b0, '0, 1'b0, '0);
            cyc("R8 unmask", '0, 1'b0, 1'b0, '0, 1'b1, '0);
            cyc("R8 remask", '0, 1'b0, 1'b0, '0, 1'b1, b);
            cyc("R8 clear cause", '0, 1'b0, 1'b1, ALL, 1'b0, '0);
        end

        report();
    end
endmodule